// File: doc/BRIEF.md
# SPI Controller Interrupt Status and Mask Unit

This unit keeps the interrupt state of an SPI controller that moves bytes through a transmit FIFO and a receive FIFO. The datapath supplies both FIFO occupancy counts, both full flags and one-cycle event pulses for transmit underflow, receive overflow and mode fail. From these inputs the unit keeps a seven-bit status word. Three of its bits are sticky event flags that software clears by writing a one to them. The other four bits are recomputed every cycle: two copy the full flags, and two compare the FIFO counts with programmable thresholds.

Software changes the interrupt mask only through two write-only style selects, one that sets bits and one that clears them. The single interrupt line is the registered OR of the masked status bits. While the controller runs in linear (memory-mapped) flash mode, the unit stops recording events and stops refreshing the live bits. A write-one-to-clear still works in that mode.

Register access uses one write strobe with a select and data, plus a read select that drives a combinational read port. The select encoding is: 0 status, 1 mask-set, 2 mask-clear, 3 mask readback, 4 transmit threshold, 5 receive threshold. Any other select reads as zero.

Top module: `spi_irq_ctrl`

## Requirements
- R1: Reset clears the status word, the mask and the interrupt output, and sets both 8-bit thresholds to 1.
- R2: A status read places the bits as follows: bit 6 TX underflow, bit 5 RX full, bit 4 RX at or above threshold, bit 3 TX full, bit 2 TX below threshold, bit 1 mode fail, bit 0 RX overflow. Bit 7 reads 0.
- R3: An underflow, overflow or mode-fail pulse sets its status bit. The bit stays set until a status write carries a 1 in that position. Writes with 0 in that position leave it unchanged.
- R4: An event pulse that lands in the same cycle as a write-one-to-clear of its bit leaves the bit set.
- R5: Status bit 4 equals (RX count >= RX threshold). It reflects the inputs one cycle after they are applied.
- R6: Status bit 2 equals (TX count < TX threshold). It reflects the inputs one cycle after they are applied.
- R7: Status bits 5 and 3 follow the RX and TX full flags one cycle later. Writing ones to those positions of the status select has no effect.
- R8: A mask-set write ORs data bits 6..0 into the mask. A mask-clear write removes the set data bits from the mask. Select 3 reads the mask.
- R9: The interrupt output equals the OR of (mask AND status) from the previous cycle.
- R10: While linear mode is high, event pulses are dropped and the live bits hold their value. A write-one-to-clear still clears sticky bits.
- R11: Threshold writes store all 8 data bits, and selects 4 and 5 read them back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| lin_mode_i | input | 1 | Linear flash mode active; freezes status updates |
| tx_count_i | input | CNT_W | TX FIFO occupancy |
| rx_count_i | input | CNT_W | RX FIFO occupancy |
| tx_full_i | input | 1 | TX FIFO full |
| rx_full_i | input | 1 | RX FIFO full |
| tx_underflow_i | input | 1 | Pulse: transfer attempted with empty TX FIFO |
| rx_overflow_i | input | 1 | Pulse: byte received into full RX FIFO and dropped |
| mode_fail_i | input | 1 | Pulse: mode fail event |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 3 | Register write select |
| wr_data_i | input | DW | Register write data |
| rd_sel_i | input | 3 | Register read select |
| rd_data_o | output | DW | Read data for rd_sel_i |
| irq_o | output | 1 | Level interrupt |

## Verification
The threshold comparators are driven with counts below, equal to and above their thresholds, including threshold 0xFF. This tells a strict compare from a non-strict one and shows whether the threshold or the reset value is in use. The sticky bits are tested with lone pulses and with a pulse that collides with a clear, and are cleared through writes aimed at other bits. These cases separate a sticky bit from a live bit and show which side wins the collision. The interrupt line is sampled in the cycle right after a mask or status change and again one cycle later, which exposes any missing or extra register stage. Linear mode is entered with a pending event and a moved count, which shows both freezing paths and confirms that clearing still works.

// File: rtl/spi_irq_pkg.sv
package spi_irq_pkg;
  localparam int NBITS = 7;

  localparam int B_RXOVF  = 0;
  localparam int B_MODEF  = 1;
  localparam int B_TXNF   = 2;
  localparam int B_TXFULL = 3;
  localparam int B_RXNE   = 4;
  localparam int B_RXFULL = 5;
  localparam int B_TXUF   = 6;

  typedef enum logic [2:0] {
    SEL_STATUS   = 3'd0,
    SEL_MASK_SET = 3'd1,
    SEL_MASK_CLR = 3'd2,
    SEL_MASK     = 3'd3,
    SEL_TX_THR   = 3'd4,
    SEL_RX_THR   = 3'd5
  } reg_sel_e;
endpackage

// File: rtl/spi_irq_sticky.sv
module spi_irq_sticky #(
  parameter int NBITS = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NBITS-1:0] set_i,
  input  logic [NBITS-1:0] clr_i,
  output logic [NBITS-1:0] q_o
);
  logic [NBITS-1:0] q;

  // set dominates clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q <= '0;
    else         q <= (q & ~clr_i) | set_i;
  end

  assign q_o = q;
endmodule

// File: rtl/spi_irq_live.sv
module spi_irq_live
  import spi_irq_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int THR_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             hold_i,
  input  logic             tx_thr_we_i,
  input  logic             rx_thr_we_i,
  input  logic [THR_W-1:0] thr_data_i,
  input  logic [CNT_W-1:0] tx_count_i,
  input  logic [CNT_W-1:0] rx_count_i,
  input  logic             tx_full_i,
  input  logic             rx_full_i,
  output logic [NBITS-1:0] live_o,
  output logic [THR_W-1:0] tx_thr_o,
  output logic [THR_W-1:0] rx_thr_o
);
  localparam int CMP_W = (CNT_W > THR_W) ? CNT_W : THR_W;

  logic [THR_W-1:0] tx_thr_q, rx_thr_q;
  logic [NBITS-1:0] live_d, live_q;
  logic [CMP_W-1:0] tx_cnt_x, rx_cnt_x, tx_thr_x, rx_thr_x;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_thr_q <= THR_W'(1);
      rx_thr_q <= THR_W'(1);
    end else begin
      if (tx_thr_we_i) tx_thr_q <= thr_data_i;
      if (rx_thr_we_i) rx_thr_q <= thr_data_i;
    end
  end

  assign tx_cnt_x = CMP_W'(tx_count_i);
  assign rx_cnt_x = CMP_W'(rx_count_i);
  assign tx_thr_x = CMP_W'(tx_thr_q);
  assign rx_thr_x = CMP_W'(rx_thr_q);

  always_comb begin
    live_d           = '0;
    live_d[B_RXFULL] = rx_full_i;
    live_d[B_TXFULL] = tx_full_i;
    live_d[B_RXNE]   = (rx_cnt_x >= rx_thr_x);
    live_d[B_TXNF]   = (tx_cnt_x <  tx_thr_x);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      live_q <= '0;
    else if (!hold_i) live_q <= live_d;
  end

  assign live_o   = live_q;
  assign tx_thr_o = tx_thr_q;
  assign rx_thr_o = rx_thr_q;
endmodule

// File: rtl/spi_irq_mask.sv
module spi_irq_mask #(
  parameter int NBITS = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             set_we_i,
  input  logic             clr_we_i,
  input  logic [NBITS-1:0] data_i,
  input  logic [NBITS-1:0] status_i,
  output logic [NBITS-1:0] mask_o,
  output logic             irq_o
);
  logic [NBITS-1:0] mask_q;
  logic             irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      if (set_we_i)      mask_q <= mask_q | data_i;
      else if (clr_we_i) mask_q <= mask_q & ~data_i;
      irq_q <= |(mask_q & status_i);
    end
  end

  assign mask_o = mask_q;
  assign irq_o  = irq_q;
endmodule

// File: rtl/spi_irq_ctrl.sv
module spi_irq_ctrl
  import spi_irq_pkg::*;
#(
  parameter int FIFO_DEPTH = 128,
  parameter int THR_W      = 8,
  parameter int CNT_W      = $clog2(FIFO_DEPTH + 1),
  parameter int DW         = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             lin_mode_i,
  input  logic [CNT_W-1:0] tx_count_i,
  input  logic [CNT_W-1:0] rx_count_i,
  input  logic             tx_full_i,
  input  logic             rx_full_i,
  input  logic             tx_underflow_i,
  input  logic             rx_overflow_i,
  input  logic             mode_fail_i,
  input  logic             wr_en_i,
  input  logic [2:0]       wr_sel_i,
  input  logic [DW-1:0]    wr_data_i,
  input  logic [2:0]       rd_sel_i,
  output logic [DW-1:0]    rd_data_o
  ,
  output logic             irq_o
);
  logic [NBITS-1:0] ev_set, ev_clr, sticky_q, live_q, status_q, mask_q;
  logic [THR_W-1:0] tx_thr, rx_thr;
  logic             we_status, we_mset, we_mclr, we_txthr, we_rxthr;

  assign we_status = wr_en_i && (wr_sel_i == SEL_STATUS);
  assign we_mset   = wr_en_i && (wr_sel_i == SEL_MASK_SET);
  assign we_mclr   = wr_en_i && (wr_sel_i == SEL_MASK_CLR);
  assign we_txthr  = wr_en_i && (wr_sel_i == SEL_TX_THR);
  assign we_rxthr  = wr_en_i && (wr_sel_i == SEL_RX_THR);

  always_comb begin
    ev_set = '0;
    if (!lin_mode_i) begin
      ev_set[B_TXUF]  = tx_underflow_i;
      ev_set[B_RXOVF] = rx_overflow_i;
      ev_set[B_MODEF] = mode_fail_i;
    end
    ev_clr = we_status ? wr_data_i[NBITS-1:0] : '0;
  end

  spi_irq_sticky #(.NBITS(NBITS)) u_sticky (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (ev_set),
    .clr_i  (ev_clr),
    .q_o    (sticky_q)
  );

  spi_irq_live #(.CNT_W(CNT_W), .THR_W(THR_W)) u_live (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .hold_i      (lin_mode_i),
    .tx_thr_we_i (we_txthr),
    .rx_thr_we_i (we_rxthr),
    .thr_data_i  (wr_data_i[THR_W-1:0]),
    .tx_count_i  (tx_count_i),
    .rx_count_i  (rx_count_i),
    .tx_full_i   (tx_full_i),
    .rx_full_i   (rx_full_i),
    .live_o      (live_q),
    .tx_thr_o    (tx_thr),
    .rx_thr_o    (rx_thr)
  );

  assign status_q = sticky_q | live_q;

  spi_irq_mask #(.NBITS(NBITS)) u_mask (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .set_we_i (we_mset),
    .clr_we_i (we_mclr),
    .data_i   (wr_data_i[NBITS-1:0]),
    .status_i (status_q),
    .mask_o   (mask_q),
    .irq_o    (irq_o)
  );

  always_comb begin
    rd_data_o = '0;
    unique case (rd_sel_i)
      SEL_STATUS:                      rd_data_o = DW'(status_q);
      SEL_MASK_SET, SEL_MASK_CLR,
      SEL_MASK:                        rd_data_o = DW'(mask_q);
      SEL_TX_THR:                      rd_data_o = DW'(tx_thr);
      SEL_RX_THR:                      rd_data_o = DW'(rx_thr);
      default:                         rd_data_o = '0;
    endcase
  end
endmodule

// File: rtl/spi_irq_chk.sv
module spi_irq_chk
  import spi_irq_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int THR_W = 8,
  parameter int DW    = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             lin_mode_i,
  input logic             tx_underflow_i,
  input logic             rx_overflow_i,
  input logic             wr_en_i,
  input logic [2:0]       wr_sel_i,
  input logic [DW-1:0]    wr_data_i,
  input logic [CNT_W-1:0] tx_count_i,
  input logic [CNT_W-1:0] rx_count_i,
  input logic [NBITS-1:0] status_q,
  input logic [NBITS-1:0] mask_q,
  input logic [THR_W-1:0] tx_thr,
  input logic [THR_W-1:0] rx_thr,
  input logic             irq_o
);
  AST_IRQ_REGISTERED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> irq_o == $past(|(mask_q & status_q))); // R9

  AST_STICKY_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_q[B_TXUF] && !(wr_en_i && wr_sel_i == SEL_STATUS && wr_data_i[B_TXUF])
    |=> status_q[B_TXUF]); // R3

  AST_EVENT_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_overflow_i && !lin_mode_i |=> status_q[B_RXOVF]); // R4

  AST_UF_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_underflow_i && !lin_mode_i |=> status_q[B_TXUF]); // R3

  AST_RX_THR_CMP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lin_mode_i |=> status_q[B_RXNE] == ($past(rx_count_i) >= $past(rx_thr))); // R5

  AST_TX_THR_CMP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lin_mode_i |=> status_q[B_TXNF] == ($past(tx_count_i) < $past(tx_thr))); // R6

  AST_LIN_FREEZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lin_mode_i |=> status_q[B_RXFULL:B_TXNF] == $past(status_q[B_RXFULL:B_TXNF])); // R10

  AST_MASK_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && wr_sel_i == SEL_MASK_SET
    |=> (mask_q & $past(wr_data_i[NBITS-1:0])) == $past(wr_data_i[NBITS-1:0])); // R8

  AST_MASK_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && wr_sel_i == SEL_MASK_CLR
    |=> (mask_q & $past(wr_data_i[NBITS-1:0])) == '0); // R8
endmodule

bind spi_irq_ctrl spi_irq_chk #(.CNT_W(CNT_W), .THR_W(THR_W), .DW(DW)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .lin_mode_i     (lin_mode_i),
  .tx_underflow_i (tx_underflow_i),
  .rx_overflow_i  (rx_overflow_i),
  .wr_en_i        (wr_en_i),
  .wr_sel_i       (wr_sel_i),
  .wr_data_i      (wr_data_i),
  .tx_count_i     (tx_count_i),
  .rx_count_i     (rx_count_i),
  .status_q       (status_q),
  .mask_q         (mask_q),
  .tx_thr         (tx_thr),
  .rx_thr         (rx_thr),
  .irq_o          (irq_o)
);

// File: tb/sim_spi_irq_ctrl.sv
`timescale 1ns/1ps
module sim_spi_irq_ctrl;
  localparam int CNT_W = 8;
  localparam int DW    = 8;
  localparam int IRQ_SEL = 7;

  logic             clk = 1'b0;
  logic             rst_ni = 1'b0;
  logic             lin_mode_i = 1'b0;
  logic [CNT_W-1:0] tx_count_i = '0, rx_count_i = '0;
  logic             tx_full_i = 1'b0, rx_full_i = 1'b0;
  logic             tx_underflow_i = 1'b0, rx_overflow_i = 1'b0, mode_fail_i = 1'b0;
  logic             wr_en_i = 1'b0;
  logic [2:0]       wr_sel_i = '0;
  logic [DW-1:0]    wr_data_i = '0;
  logic [2:0]       rd_sel_i = '0;
  logic [DW-1:0]    rd_data_o;
  logic             irq_o;

  always #2.5 clk = ~clk;

  spi_irq_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_ni), .lin_mode_i(lin_mode_i),
    .tx_count_i(tx_count_i), .rx_count_i(rx_count_i),
    .tx_full_i(tx_full_i), .rx_full_i(rx_full_i),
    .tx_underflow_i(tx_underflow_i), .rx_overflow_i(rx_overflow_i),
    .mode_fail_i(mode_fail_i), .wr_en_i(wr_en_i), .wr_sel_i(wr_sel_i),
    .wr_data_i(wr_data_i), .rd_sel_i(rd_sel_i), .rd_data_o(rd_data_o),
    .irq_o(irq_o)
  );

  typedef struct {
    int    sel;
    int    exp;
    string tag;
  } item_t;

  item_t exp_q[$];
  int    n_checks = 0;
  int    n_errors = 0;
  bit    finished = 1'b0;

  // monitor: pops one expectation per falling edge and compares
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      item_t it;
      int    act;
      it = exp_q.pop_front();
      if (it.sel != IRQ_SEL) rd_sel_i = it.sel[2:0];
      #1;
      act = (it.sel == IRQ_SEL) ? int'(irq_o) : int'(rd_data_o);
      n_checks++;
      if (act != it.exp) begin
        n_errors++;
        $display("FAIL %s: actual=0x%0h expected=0x%0h", it.tag, act, it.exp);
      end
    end
  end

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic expect_rd(input int sel, input int exp, input string tag);
    item_t it;
    it.sel = sel; it.exp = exp; it.tag = tag;
    exp_q.push_back(it);
    tick();
  endtask

  task automatic wr(input int sel, input int data);
    wr_en_i = 1'b1; wr_sel_i = sel[2:0]; wr_data_i = data[DW-1:0];
    tick();
    wr_en_i = 1'b0;
  endtask

  task automatic pulse_uf();  tx_underflow_i = 1'b1; tick(); tx_underflow_i = 1'b0; endtask
  task automatic pulse_ovf(); rx_overflow_i  = 1'b1; tick(); rx_overflow_i  = 1'b0; endtask
  task automatic pulse_mf();  mode_fail_i    = 1'b1; tick(); mode_fail_i    = 1'b0; endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
  endtask

  initial begin
    #(5.0 * 200000);
    if (!finished) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog R1..: actual=hung expected=done");
      summary();
      $finish;
    end
  end

  initial begin
    // R1 reset state
    expect_rd(0, 8'h00, "R1 status in reset");
    expect_rd(3, 8'h00, "R1 mask in reset");
    expect_rd(4, 8'h01, "R1 tx threshold in reset");
    expect_rd(5, 8'h01, "R1 rx threshold in reset");
    expect_rd(IRQ_SEL, 0, "R1 irq in reset");
    rst_ni = 1'b1;
    tick();
    expect_rd(0, 8'h04, "R6 tx 0 below thr 1");
    expect_rd(0, 8'h04, "R2 bit7 reads zero, layout");

    // R5 rx threshold compare
    rx_count_i = 8'd3; tick();
    expect_rd(0, 8'h14, "R5 rx count above thr");
    wr(5, 3); rx_count_i = 8'd2; tick();
    expect_rd(0, 8'h04, "R5 rx count below thr");
    rx_count_i = 8'd3; tick();
    expect_rd(0, 8'h14, "R5 rx count equal thr");
    rx_count_i = 8'd0; tick();
    expect_rd(0, 8'h04, "R5 rx empty");
    expect_rd(5, 8'h03, "R11 rx thr readback");

    // R6 tx threshold compare
    wr(4, 5); tx_count_i = 8'd4; tick();
    expect_rd(0, 8'h04, "R6 tx one below thr");
    tx_count_i = 8'd5; tick();
    expect_rd(0, 8'h00, "R6 tx equal thr");
    tx_count_i = 8'd0; tick();

    // R7 full flags live, not writable
    rx_full_i = 1'b1; tx_full_i = 1'b1; tick();
    expect_rd(0, 8'h2C, "R7 full flags");
    wr(0, 8'h7F);
    expect_rd(0, 8'h2C, "R7 clear ignored on live bits");
    rx_full_i = 1'b0; tx_full_i = 1'b0; tick();
    expect_rd(0, 8'h04, "R7 full flags drop");

    // R3 sticky events
    pulse_uf();
    expect_rd(0, 8'h44, "R3 underflow sets");
    pulse_ovf();
    expect_rd(0, 8'h45, "R3 overflow sets");
    wr(0, 8'h01);
    expect_rd(0, 8'h44, "R3 clear overflow only");
    wr(0, 8'h40);
    expect_rd(0, 8'h04, "R3 clear underflow");
    pulse_mf();
    expect_rd(0, 8'h06, "R3 mode fail sets");
    wr(0, 8'h02);
    expect_rd(0, 8'h04, "R3 clear mode fail");

    // R4 event wins over clear
    tx_underflow_i = 1'b1; wr_en_i = 1'b1; wr_sel_i = 3'd0; wr_data_i = 8'h40;
    tick();
    tx_underflow_i = 1'b0; wr_en_i = 1'b0;
    expect_rd(0, 8'h44, "R4 event beats clear");
    wr(0, 8'h40);
    expect_rd(0, 8'h04, "R4 later clear");

    // R8 mask set/clear
    wr(1, 8'h41); expect_rd(3, 8'h41, "R8 mask set");
    wr(1, 8'h02); expect_rd(3, 8'h43, "R8 mask set ORs");
    wr(2, 8'h01); expect_rd(3, 8'h42, "R8 mask clear");
    wr(2, 8'h7F); expect_rd(3, 8'h00, "R8 mask clear all");

    // R9 registered interrupt
    wr(1, 8'h04);
    expect_rd(IRQ_SEL, 0, "R9 irq one cycle late on mask set");
    expect_rd(IRQ_SEL, 1, "R9 irq asserts");
    wr(2, 8'h04);
    expect_rd(IRQ_SEL, 1, "R9 irq one cycle late on mask clear");
    expect_rd(IRQ_SEL, 0, "R9 irq drops");
    wr(1, 8'h01);
    pulse_ovf();
    expect_rd(IRQ_SEL, 0, "R9 irq late on sticky event");
    expect_rd(IRQ_SEL, 1, "R9 irq from sticky event");
    wr(0, 8'h01);
    expect_rd(IRQ_SEL, 1, "R9 irq late on status clear");
    expect_rd(IRQ_SEL, 0, "R9 irq after status clear");
    wr(2, 8'h01);

    // R10 linear mode freeze
    pulse_ovf();
    expect_rd(0, 8'h05, "R10 pending overflow before freeze");
    lin_mode_i = 1'b1; rx_count_i = 8'd3; tick();
    pulse_uf();
    expect_rd(0, 8'h05, "R10 frozen live bits, event dropped");
    wr(0, 8'h01);
    expect_rd(0, 8'h04, "R10 clear works while frozen");
    lin_mode_i = 1'b0; tick();
    expect_rd(0, 8'h14, "R10 live bits resume");
    rx_count_i = 8'd0; tick();

    // R11 full-width threshold
    wr(4, 8'hFF);
    expect_rd(4, 8'hFF, "R11 tx thr readback");
    tx_count_i = 8'hFE; tick();
    expect_rd(0, 8'h04, "R6 count FE below thr FF");
    tx_count_i = 8'hFF; tick();
    expect_rd(0, 8'h00, "R6 count FF not below thr FF");

    tick(); tick();
    finished = 1'b1;
    summary();
    $finish;
  end
endmodule